// File: doc/BRIEF.md
# Hardware Queueing Ticket Lock

This block hands out a small set of lock resources to a fixed group of requesters, strictly in the order in which they asked. Each lock keeps two wrapping counters: the next ticket to be issued and the ticket now being served. An accepted acquire atomically takes the next ticket of the chosen lock. A requester holds the lock once the serving counter reaches its ticket. A release by the holder advances the serving counter by one.

Each requester has its own acquire strobe, release strobe and lock-select field. It also has one grant output that stays high for the whole time it holds the lock. A release raises exactly one new grant: the next ticket in line. Every other waiter sees no change on its outputs. A release from a requester that does not hold the named lock is dropped and flagged on a one-cycle error output.

Top module: `ticket_lock_mgr`

## Requirements
- R1: After reset every grant output and the error output are low, and every lock is free: its ticket and serving counters are both zero.
- R2: An acquire from an idle requester on a free lock is sampled on one rising edge. The requester's grant goes high on the second rising edge after that.
- R3: Acquires on one lock that are sampled on different edges are granted in the order of those edges.
- R4: Acquires on one lock that are sampled on the same edge take tickets in ascending requester-index order. Index 0 is served first.
- R5: A release by the holder of lock L, with the lock-select field equal to L, is sampled on one edge. The holder's grant drops on that edge. The next waiter's grant rises on the following edge, one cycle after the serving counter advances.
- R6: At most one requester holds a given lock at any time. A release changes the grant of no waiter other than the next one in line.
- R7: Once asserted, a grant stays high until its holder issues a valid release.
- R8: Some releases are invalid: the requester is not holding, or its lock-select differs from the lock it holds. An invalid release changes no grant and no counter. The error output is high for exactly the cycle after such a release is sampled.
- R9: An acquire from a requester that is already waiting or holding is ignored and takes no ticket.
- R10: Locks are independent. Different requesters may hold different locks at the same time.
- R11: Ticket and serving counters are clog2(N_REQ)+1 bits wide and wrap. Order stays correct after many more tickets than the counter range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acq_i | input | N_REQ | Acquire strobe, one bit per requester |
| rel_i | input | N_REQ | Release strobe, one bit per requester |
| lock_id_i | input | N_REQ*LW | Lock select per requester (bits r*LW +: LW), used by both acquire and release |
| gnt_o | output | N_REQ | Grant, high while the requester holds its lock |
| err_o | output | 1 | One-cycle pulse after an invalid release |

## Verification
Requesters acquire in the same cycle, in staggered cycles and while already queued. A design that gives same-cycle acquires equal tickets would grant two requesters at once. A design that ordered them by anything but index would serve them in the wrong order. A design that counted a repeated acquire would leave a phantom ticket, so a later requester would never be granted. Bad releases are sent by a waiter and by a holder naming the wrong lock; a design that accepted either would drop a grant or advance the queue. More than five rounds of four tickets each run the counters through several wraps, which exposes comparisons that fail across the wrap point.

// File: rtl/tl_pkg.sv
package tl_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_WAIT = 2'd1,
    SLOT_HOLD = 2'd2
  } slot_st_e;

  function automatic int unsigned id_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tl_lock_ctr.sv
module tl_lock_ctr #(
  parameter int N_REQ = 4,
  parameter int TW    = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [TW-1:0] take_i,
  input  logic          adv_i,
  output logic [TW-1:0] tkt_o,
  output logic [TW-1:0] srv_o
);
  logic [TW-1:0] tkt_q, srv_q, outst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tkt_q <= '0;
      srv_q <= '0;
    end else begin
      tkt_q <= tkt_q + take_i;
      if (adv_i) srv_q <= srv_q + TW'(1);
    end
  end

  assign tkt_o = tkt_q;
  assign srv_o = srv_q;
  assign outst = tkt_q - srv_q;

  assert_serving_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> srv_q == $past(srv_q) + TW'(1));
  assert_serving_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(srv_q));
  assert_no_overflow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outst <= TW'(N_REQ));
endmodule

// File: rtl/tl_ticket_alloc.sv
module tl_ticket_alloc #(
  parameter int N_REQ  = 4,
  parameter int N_LOCK = 2,
  parameter int TW     = 3,
  parameter int LW     = 1
) (
  input  logic [N_REQ-1:0]     acq_ok_i,
  input  logic [N_REQ*LW-1:0]  lock_id_i,
  input  logic [N_LOCK*TW-1:0] tkt_i,
  output logic [N_REQ*TW-1:0]  ticket_o,
  output logic [N_LOCK*TW-1:0] take_o
);
  // same-cycle acquires on one lock: lower index gets the lower ticket
  always_comb begin
    ticket_o = '0;
    for (int r = 0; r < N_REQ; r++) begin
      logic [TW-1:0] off;
      logic [TW-1:0] base;
      off  = '0;
      base = '0;
      for (int j = 0; j < r; j++) begin
        if (acq_ok_i[j] && lock_id_i[j*LW +: LW] == lock_id_i[r*LW +: LW])
          off = off + TW'(1);
      end
      for (int l = 0; l < N_LOCK; l++) begin
        if (lock_id_i[r*LW +: LW] == LW'(l)) base = tkt_i[l*TW +: TW];
      end
      ticket_o[r*TW +: TW] = base + off;
    end
  end

  always_comb begin
    take_o = '0;
    for (int l = 0; l < N_LOCK; l++) begin
      logic [TW-1:0] cnt;
      cnt = '0;
      for (int r = 0; r < N_REQ; r++) begin
        if (acq_ok_i[r] && lock_id_i[r*LW +: LW] == LW'(l)) cnt = cnt + TW'(1);
      end
      take_o[l*TW +: TW] = cnt;
    end
  end
endmodule

// File: rtl/tl_req_slot.sv
module tl_req_slot
  import tl_pkg::*;
#(
  parameter int TW = 3,
  parameter int LW = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acq_ok_i,
  input  logic [TW-1:0] ticket_i,
  input  logic [LW-1:0] lock_i,
  input  logic [TW-1:0] srv_i,
  input  logic          rel_i,
  output logic          idle_o,
  output logic          hold_o,
  output logic [LW-1:0] lock_o,
  output logic          rel_ok_o,
  output logic          rel_bad_o
);
  slot_st_e      st_q;
  logic [TW-1:0] tkt_q;
  logic [LW-1:0] lock_q;

  assign idle_o    = (st_q == SLOT_IDLE);
  assign hold_o    = (st_q == SLOT_HOLD);
  assign lock_o    = lock_q;
  assign rel_ok_o  = rel_i && hold_o && (lock_i == lock_q);
  assign rel_bad_o = rel_i && !rel_ok_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SLOT_IDLE;
      tkt_q  <= '0;
      lock_q <= '0;
    end else begin
      unique case (st_q)
        SLOT_IDLE: if (acq_ok_i) begin
          st_q   <= SLOT_WAIT;
          tkt_q  <= ticket_i;
          lock_q <= lock_i;
        end
        SLOT_WAIT: if (srv_i == tkt_q) st_q <= SLOT_HOLD;
        SLOT_HOLD: if (rel_ok_o) st_q <= SLOT_IDLE;
        default:   st_q <= SLOT_IDLE;
      endcase
    end
  end

  assert_grant_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o && !rel_i |=> hold_o);
  assert_turn_grant_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == SLOT_WAIT && srv_i == tkt_q |=> hold_o);
  assert_wait_stays_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == SLOT_WAIT && srv_i != tkt_q |=> st_q == SLOT_WAIT);
  assert_reacq_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == SLOT_WAIT |=> $stable(tkt_q));
endmodule

// File: rtl/ticket_lock_mgr.sv
module ticket_lock_mgr
  import tl_pkg::*;
#(
  parameter int N_REQ  = 4,
  parameter int N_LOCK = 2,
  localparam int TW    = $clog2(N_REQ) + 1,
  localparam int LW    = id_w(N_LOCK)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_REQ-1:0]    acq_i,
  input  logic [N_REQ-1:0]    rel_i,
  input  logic [N_REQ*LW-1:0] lock_id_i,
  output logic [N_REQ-1:0]    gnt_o,
  output logic                err_o
);
  logic [N_REQ-1:0]     idle, hold, rel_ok, rel_bad, acq_ok;
  logic [N_REQ*LW-1:0]  held_lock;
  logic [N_REQ*TW-1:0]  ticket, srv_sel;
  logic [N_LOCK*TW-1:0] tkt, srv, take;
  logic [N_LOCK-1:0]    adv;
  logic                 err_q;

  assign acq_ok = acq_i & idle;

  tl_ticket_alloc #(.N_REQ(N_REQ), .N_LOCK(N_LOCK), .TW(TW), .LW(LW)) u_alloc (
    .acq_ok_i (acq_ok),
    .lock_id_i(lock_id_i),
    .tkt_i    (tkt),
    .ticket_o (ticket),
    .take_o   (take)
  );

  for (genvar l = 0; l < N_LOCK; l++) begin : g_lock
    logic [N_REQ-1:0] owners;

    always_comb begin
      adv[l] = 1'b0;
      for (int r = 0; r < N_REQ; r++) begin
        owners[r] = hold[r] && held_lock[r*LW +: LW] == LW'(l);
        if (rel_ok[r] && held_lock[r*LW +: LW] == LW'(l)) adv[l] = 1'b1;
      end
    end

    tl_lock_ctr #(.N_REQ(N_REQ), .TW(TW)) u_ctr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .take_i(take[l*TW +: TW]),
      .adv_i (adv[l]),
      .tkt_o (tkt[l*TW +: TW]),
      .srv_o (srv[l*TW +: TW])
    );

    assert_one_holder_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(owners));
  end

  for (genvar r = 0; r < N_REQ; r++) begin : g_req
    always_comb begin
      srv_sel[r*TW +: TW] = '0;
      for (int l = 0; l < N_LOCK; l++) begin
        if (held_lock[r*LW +: LW] == LW'(l)) srv_sel[r*TW +: TW] = srv[l*TW +: TW];
      end
    end

    tl_req_slot #(.TW(TW), .LW(LW)) u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .acq_ok_i (acq_ok[r]),
      .ticket_i (ticket[r*TW +: TW]),
      .lock_i   (lock_id_i[r*LW +: LW]),
      .srv_i    (srv_sel[r*TW +: TW]),
      .rel_i    (rel_i[r]),
      .idle_o   (idle[r]),
      .hold_o   (hold[r]),
      .lock_o   (held_lock[r*LW +: LW]),
      .rel_ok_o (rel_ok[r]),
      .rel_bad_o(rel_bad[r])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= |rel_bad;
  end

  assign gnt_o = hold;
  assign err_o = err_q;

  assert_err_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(rel_i & ~gnt_o) |=> err_o);
  assert_err_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|rel_i) |=> !err_o);
  assert_single_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(gnt_o & ~$past(gnt_o)) <= N_LOCK);
endmodule

// File: tb/sim_ticket_lock_mgr.sv
module sim_ticket_lock_mgr;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int NL = 2;
  localparam int MOD = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0] acq = '0, rel = '0;
  logic [N-1:0] lock_id = '0;
  logic [N-1:0] gnt;
  logic err;

  int checks = 0, errs = 0;
  bit done = 0;

  int m_st[N], m_tk[N], m_lk[N], m_tkt[NL], m_srv[NL];
  bit m_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  ticket_lock_mgr #(.N_REQ(N), .N_LOCK(NL)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .acq_i(acq), .rel_i(rel),
    .lock_id_i(lock_id), .gnt_o(gnt), .err_o(err)
  );

  // behavioural reference: 0 idle, 1 waiting, 2 holding
  always @(posedge clk) begin
    if (!rst_ni) begin
      for (int r = 0; r < N; r++) begin m_st[r] = 0; m_tk[r] = 0; m_lk[r] = 0; end
      for (int l = 0; l < NL; l++) begin m_tkt[l] = 0; m_srv[l] = 0; end
      m_err = 0;
    end else begin
      int st_o[N];
      int srv_o[NL];
      bit bad;
      bad = 0;
      for (int r = 0; r < N; r++) st_o[r] = m_st[r];
      for (int l = 0; l < NL; l++) srv_o[l] = m_srv[l];
      for (int r = 0; r < N; r++)
        if (rel[r]) begin
          if (st_o[r] == 2 && int'(lock_id[r]) == m_lk[r]) begin
            m_st[r] = 0;
            m_srv[m_lk[r]] = (m_srv[m_lk[r]] + 1) % MOD;
          end else bad = 1;
        end
      for (int r = 0; r < N; r++)
        if (st_o[r] == 1 && srv_o[m_lk[r]] == m_tk[r]) m_st[r] = 2;
      for (int r = 0; r < N; r++)
        if (acq[r] && st_o[r] == 0) begin
          m_st[r] = 1;
          m_lk[r] = int'(lock_id[r]);
          m_tk[r] = m_tkt[m_lk[r]];
          m_tkt[m_lk[r]] = (m_tkt[m_lk[r]] + 1) % MOD;
        end
      m_err = bad;
    end
  end

  // per-cycle comparison against the reference (R3 R5 R6 R7)
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      logic [N-1:0] exp_g;
      for (int r = 0; r < N; r++) exp_g[r] = (m_st[r] == 2);
      checks++;
      if (gnt !== exp_g) begin
        errs++;
        $display("FAIL R6 model grant act=%b exp=%b t=%0t", gnt, exp_g, $time);
      end
      checks++;
      if (err !== m_err) begin
        errs++;
        $display("FAIL R8 model err act=%b exp=%b t=%0t", err, m_err, $time);
      end
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk_g(string tag, logic [N-1:0] exp);
    checks++;
    if (gnt !== exp) begin
      errs++;
      $display("FAIL %s gnt act=%b exp=%b", tag, gnt, exp);
    end
  endtask

  task automatic chk_e(string tag, logic exp);
    checks++;
    if (err !== exp) begin
      errs++;
      $display("FAIL %s err act=%b exp=%b", tag, err, exp);
    end
  endtask

  task automatic acq_go(logic [N-1:0] who, logic [N-1:0] lk);
    acq = who;
    lock_id = lk;
    step();
    acq = '0;
  endtask

  task automatic rel_go(int r, logic lk);
    rel[r] = 1'b1;
    lock_id[r] = lk;
    step();
    rel = '0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) step();
    chk_g("R1 reset", 4'b0000);
    chk_e("R1 reset", 1'b0);
    rst_ni = 1'b1;
    step();

    // R2 first acquire on a free lock
    acq_go(4'b0001, 4'b0000);
    chk_g("R2 one edge", 4'b0000);
    step();
    chk_g("R2 two edges", 4'b0001);

    // R4 same-cycle acquires, R7 hold while others wait
    acq_go(4'b1110, 4'b0000);
    repeat (3) step();
    chk_g("R7 holder kept", 4'b0001);
    rel_go(0, 1'b0);
    chk_g("R5 holder drops", 4'b0000);
    step();
    chk_g("R4 index1 first", 4'b0010);
    rel_go(1, 1'b0);
    step();
    chk_g("R4 index2 next", 4'b0100);
    rel_go(2, 1'b0);
    step();
    chk_g("R4 index3 last", 4'b1000);
    rel_go(3, 1'b0);
    step();
    chk_g("R5 queue empty", 4'b0000);

    // R3 arrival order across cycles on lock 1: 2, 0, 1
    acq_go(4'b0100, 4'b1111);
    acq_go(4'b0001, 4'b1111);
    acq_go(4'b0010, 4'b1111);
    step();
    chk_g("R3 first arrival", 4'b0100);

    // R8 release by a waiter, then by the holder with the wrong lock
    rel_go(0, 1'b1);
    chk_e("R8 waiter release", 1'b1);
    chk_g("R8 waiter release", 4'b0100);
    step();
    chk_e("R8 pulse ends", 1'b0);
    rel_go(2, 1'b0);
    chk_e("R8 wrong lock", 1'b1);
    chk_g("R8 wrong lock", 4'b0100);
    step();
    chk_g("R8 holder kept", 4'b0100);

    // R9 repeated acquire from a waiting requester
    acq_go(4'b0001, 4'b1111);
    step();
    // R10 second lock granted alongside
    acq_go(4'b1000, 4'b0000);
    step();
    chk_g("R10 two locks", 4'b1100);

    rel_go(2, 1'b1);
    chk_g("R5 drop only holder", 4'b1000);
    step();
    chk_g("R3 second arrival", 4'b1001);
    rel_go(0, 1'b1);
    step();
    chk_g("R3 third arrival", 4'b1010);
    rel_go(1, 1'b1);
    step();
    chk_g("R9 no phantom", 4'b1000);
    acq_go(4'b0001, 4'b1111);
    step();
    chk_g("R9 queue intact", 4'b1001);
    rel_go(0, 1'b1);
    rel_go(3, 1'b0);
    step();
    chk_g("R10 all free", 4'b0000);

    // R11 counter wrap: ten rounds of four tickets
    for (int k = 0; k < 10; k++) begin
      acq_go(4'b1111, 4'b0000);
      step();
      chk_g("R11 round start", 4'b0001);
      for (int r = 0; r < N; r++) begin
        rel_go(r, 1'b0);
        step();
        chk_g("R11 round order", 4'((5'b00010 << r) & 5'b01111));
      end
    end

    step();
    finish_run();
  end
endmodule